// File: doc/BRIEF.md
# Byte-Masked Remote Mailbox Writer

This block takes 64-bit command writes on a small register window and turns each accepted command into a 32-bit write into the control/status space of a chosen target core. It uses a simple master request interface. The 64-bit command holds four things: the data word in its upper half, a target core number, a 4-bit byte-keep mask, and low address bits. When the mask is nonzero, the block first reads the current target word. It then keeps the old byte in every lane whose mask bit is set, fills the other lanes from the command, and writes the merged word back. When the mask is zero, it writes the full word without a read.

Two command offsets exist. A "mailbox" command aims at a fixed mailbox base plus 0x20 plus a word offset taken from the command. A "direct" command aims at the 16-bit address carried in the command itself. Every request carries the target core number, so the write is made on that core's behalf. A command that names a core that does not exist is dropped and reported with a one-cycle error pulse.

The sequencer has four states:
- `ST_IDLE`: ready for a command.
- `ST_FETCH`: read request outstanding.
- `ST_STORE`: write request outstanding.
- `ST_FAULT`: one-cycle error report.

The transitions are:
- idle→fetch: valid command, nonzero mask.
- idle→store: valid command, zero mask.
- idle→fault: unknown core.
- fetch→store: read acknowledged.
- store→idle: write acknowledged.
- fault→idle: unconditional.

Top module: `mbx_remote_writer`

## Requirements
- R1: A command is taken only when `cmd_wide`=1 (64-bit access), `cmd_addr` (12 bits) is below 0x118, and it equals MAIL_OFS (default 0x048) or ANY_OFS (default 0x058). Any other write is accepted on the handshake but causes no bus request, no error and no busy.
- R2: The target core is command bits 25:16. If it is not below NUM_CORES (default 4), the command makes no bus request, and `cmd_err` is 1 for exactly the one cycle after acceptance.
- R3: The byte-keep mask is command bits 30:27. Mask bit i governs byte i, bits 8i+7:8i, of the 32-bit word. The new data is command bits 63:32.
- R4: With a nonzero mask, a read (`m_we`=0) is issued first and then a write (`m_we`=1) to the same address. In the write word, each byte whose mask bit is 1 holds the byte that was read, and every other byte holds the new data.
- R5: With a zero mask, no read is issued, and a single write of command bits 63:32 is made.
- R6: For a mailbox command, the target address is MBOX_BASE (default 0) + 0x20 + (command & 0x1C).
- R7: For a direct command, the target address is command bits 15:0.
- R8: `m_core` carries the command's target core number on every request.
- R9: While `m_req` is high and `m_ack` is low, `m_we`, `m_addr`, `m_wdata` and `m_core` stay unchanged.
- R10: `busy` is high from the cycle after acceptance until the final write is acknowledged, or for the single fault cycle. `cmd_ready` is low while busy, and after reset the block is idle with `cmd_ready`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_ready | output | 1 | Block can take a command |
| cmd_wide | input | 1 | 1 = 64-bit access |
| cmd_addr | input | 12 | Command register offset |
| cmd_data | input | 64 | Command word |
| cmd_err | output | 1 | Decode error pulse (unknown core) |
| busy | output | 1 | Command in progress |
| m_req | output | 1 | Master request |
| m_we | output | 1 | 1 = write, 0 = read |
| m_addr | output | 16 | Target address |
| m_wdata | output | 32 | Write data |
| m_core | output | 10 | Target core number for the access |
| m_ack | input | 1 | Request accepted/completed this cycle |
| m_rdata | input | 32 | Read data, valid with `m_ack` on a read |

## Verification
Assertions check several things on every cycle:
- A stalled request keeps its address, data, direction and core stable.
- An acknowledged read is followed at once by a write to the same address.
- The choice between fetch and store follows the mask.
- An unknown core raises the error pulse without a bus request.
- `busy` drops right after the final write acknowledge.

Only the bench's scenarios can show the rest: the merged byte values against a modelled memory, the two address-formation rules including bits outside the word-offset field, and that writes of the wrong width or offset leave memory untouched. They also show back-pressure when commands arrive back to back under a slow responder.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int ADDR_W = 16;
    localparam int CORE_W = 10;
    localparam int WORD_W = 32;
    localparam int BYTES  = WORD_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_STORE = 2'd2,
        ST_FAULT = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CORE_W-1:0] core;
        logic [BYTES-1:0]  keep;
        logic [WORD_W-1:0] word;
    } mbx_cmd_t;
endpackage

// File: rtl/mbx_cmd_decode.sv
module mbx_cmd_decode
    import mbx_pkg::*;
#(
    parameter logic [11:0]       MAIL_OFS  = 12'h048,
    parameter logic [11:0]       ANY_OFS   = 12'h058,
    parameter logic [11:0]       WINDOW    = 12'h118,
    parameter logic [ADDR_W-1:0] MBOX_BASE = '0,
    parameter int unsigned       NUM_CORES = 4
) (
    input  logic        wide,
    input  logic [11:0] ofs,
    input  logic [63:0] data,
    output logic        hit,
    output logic        id_ok,
    output mbx_cmd_t    cmd
);
    localparam logic [ADDR_W-1:0] MBOX_SLOT0 = MBOX_BASE + ADDR_W'(16'h0020);

    logic in_win;
    logic is_mail;
    logic is_any;
    logic [ADDR_W-1:0] mail_addr;

    assign in_win  = ofs < WINDOW;
    assign is_mail = wide && in_win && (ofs == MAIL_OFS);
    assign is_any  = wide && in_win && (ofs == ANY_OFS);
    assign hit     = is_mail || is_any;

    // word offset: bits 4:2 only, byte lanes and upper bits dropped
    assign mail_addr = MBOX_SLOT0 + ADDR_W'({data[4:2], 2'b00});

    always_comb begin
        cmd.core = data[25:16];
        cmd.keep = data[30:27];
        cmd.word = data[63:32];
        cmd.addr = is_mail ? mail_addr : data[15:0];
    end

    assign id_ok = 32'(cmd.core) < NUM_CORES;
endmodule

// File: rtl/mbx_byte_merge.sv
module mbx_byte_merge
    import mbx_pkg::*;
(
    input  logic [BYTES-1:0]  keep,
    input  logic [WORD_W-1:0] old_word,
    input  logic [WORD_W-1:0] new_word,
    output logic [WORD_W-1:0] merged
);
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign merged[8*i +: 8] = keep[i] ? old_word[8*i +: 8] : new_word[8*i +: 8];
    end
endmodule

// File: rtl/mbx_seq_fsm.sv
module mbx_seq_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic id_ok,
    input  logic need_read,
    input  logic ack,
    output logic req,
    output logic we,
    output logic busy,
    output logic ready,
    output logic err,
    output logic load_merge
);
    seq_state_e state_q;
    seq_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (!id_ok)         state_d = ST_FAULT;
                    else if (need_read) state_d = ST_FETCH;
                    else                state_d = ST_STORE;
                end
            end
            ST_FETCH: if (ack) state_d = ST_STORE;
            ST_STORE: if (ack) state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req        = 1'b0;
        we         = 1'b0;
        busy       = 1'b1;
        ready      = 1'b0;
        err        = 1'b0;
        load_merge = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy  = 1'b0;
                ready = 1'b1;
            end
            ST_FETCH: begin
                req        = 1'b1;
                load_merge = ack;
            end
            ST_STORE: begin
                req = 1'b1;
                we  = 1'b1;
            end
            ST_FAULT: err = 1'b1;
            default: ;
        endcase
    end

    p_store_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && ack) |=> !busy);
    p_fault_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!req && busy));
endmodule

// File: rtl/mbx_remote_writer.sv
module mbx_remote_writer
    import mbx_pkg::*;
#(
    parameter logic [11:0]       MAIL_OFS  = 12'h048,
    parameter logic [11:0]       ANY_OFS   = 12'h058,
    parameter logic [11:0]       WINDOW    = 12'h118,
    parameter logic [ADDR_W-1:0] MBOX_BASE = '0,
    parameter int unsigned       NUM_CORES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_wide,
    input  logic [11:0]        cmd_addr,
    input  logic [63:0]        cmd_data,
    output logic               cmd_err,
    output logic               busy,
    output logic               m_req,
    output logic               m_we,
    output logic [ADDR_W-1:0]  m_addr,
    output logic [WORD_W-1:0]  m_wdata,
    output logic [CORE_W-1:0]  m_core,
    input  logic               m_ack,
    input  logic [WORD_W-1:0]  m_rdata
);
    logic     hit;
    logic     id_ok;
    logic     accept;
    logic     load_merge;
    mbx_cmd_t dec_cmd;
    mbx_cmd_t cmd_q;
    logic [WORD_W-1:0] merged;

    mbx_cmd_decode #(
        .MAIL_OFS (MAIL_OFS),
        .ANY_OFS  (ANY_OFS),
        .WINDOW   (WINDOW),
        .MBOX_BASE(MBOX_BASE),
        .NUM_CORES(NUM_CORES)
    ) u_dec (
        .wide (cmd_wide),
        .ofs  (cmd_addr),
        .data (cmd_data),
        .hit  (hit),
        .id_ok(id_ok),
        .cmd  (dec_cmd)
    );

    assign accept = cmd_valid && cmd_ready && hit;

    mbx_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .id_ok     (id_ok),
        .need_read (|dec_cmd.keep),
        .ack       (m_ack),
        .req       (m_req),
        .we        (m_we),
        .busy      (busy),
        .ready     (cmd_ready),
        .err       (cmd_err),
        .load_merge(load_merge)
    );

    mbx_byte_merge u_merge (
        .keep    (cmd_q.keep),
        .old_word(m_rdata),
        .new_word(cmd_q.word),
        .merged  (merged)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (accept) begin
            cmd_q <= dec_cmd;
        end else if (load_merge) begin
            cmd_q.word <= merged;
        end
    end

    assign m_addr  = cmd_q.addr;
    assign m_wdata = cmd_q.word;
    assign m_core  = cmd_q.core;

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack) |=> (m_req && $stable(m_we) && $stable(m_addr)
                               && $stable(m_wdata) && $stable(m_core)));
    p_fetch_then_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_we && m_ack) |=> (m_req && m_we && $stable(m_addr) && $stable(m_core)));
    p_nonzero_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && id_ok && (dec_cmd.keep != '0)) |=> (m_req && !m_we));
    p_zero_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && id_ok && (dec_cmd.keep == '0)) |=> (m_req && m_we));
    p_bad_core_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !id_ok) |=> cmd_err);
    p_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !hit) |=> !busy);
endmodule

// File: tb/sim_mbx_remote_writer.sv
module sim_mbx_remote_writer;
    localparam time         CLK_PERIOD = 10ns;
    localparam int unsigned NCORE      = 4;
    localparam logic [11:0] MAIL       = 12'h048;
    localparam logic [11:0] ANY        = 12'h058;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_wide = 1'b0;
    logic [11:0] cmd_addr = '0;
    logic [63:0] cmd_data = '0;
    logic        cmd_err;
    logic        busy;
    logic        m_req;
    logic        m_we;
    logic [15:0] m_addr;
    logic [31:0] m_wdata;
    logic [9:0]  m_core;
    logic        m_ack = 1'b0;
    logic [31:0] m_rdata = '0;

    mbx_remote_writer #(.MAIL_OFS(MAIL), .ANY_OFS(ANY), .NUM_CORES(NCORE)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_wide(cmd_wide), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_err(cmd_err), .busy(busy), .m_req(m_req), .m_we(m_we),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_core(m_core),
        .m_ack(m_ack), .m_rdata(m_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        bit        we;
        bit [15:0] addr;
        bit [9:0]  core;
        bit [31:0] data;
    } xact_t;

    xact_t     q[$];
    bit [31:0] mem[int];
    int        compared = 0;
    int        mismatched = 0;
    bit        exp_err = 0;
    int        lat = 0;
    int        wcnt = 0;
    bit        done = 0;

    function automatic bit [31:0] rd(input bit [15:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 32'h0;
    endfunction

    function automatic bit [63:0] mk(input bit [31:0] w, input bit [3:0] m,
                                     input bit [9:0] id, input bit [15:0] lo);
        return {w, 1'b0, m, 1'b0, id, lo};
    endfunction

    task automatic chk(input string tag, input bit [63:0] act, input bit [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural model of one accepted command
    task automatic model(input bit wide, input bit [11:0] ofs, input bit [63:0] d);
        bit [15:0] a;
        bit [31:0] w;
        bit [31:0] old;
        xact_t     x;
        if (!(wide && ofs < 12'h118 && (ofs == MAIL || ofs == ANY))) return;
        if (int'(d[25:16]) >= int'(NCORE)) begin
            exp_err = 1;
            return;
        end
        a = (ofs == MAIL) ? 16'h0020 + 16'(d[4:2]) * 16'd4 : d[15:0];
        old = rd(a);
        w = d[63:32];
        for (int i = 0; i < 4; i++)
            if (d[27+i]) w[8*i +: 8] = old[8*i +: 8];
        if (d[30:27] != 4'b0) begin
            x = '{we: 1'b0, addr: a, core: d[25:16], data: 32'h0};
            q.push_back(x);
        end
        x = '{we: 1'b1, addr: a, core: d[25:16], data: w};
        q.push_back(x);
    endtask

    task automatic send(input bit wide, input bit [11:0] ofs, input bit [63:0] d);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_wide  = wide;
        cmd_addr  = ofs;
        cmd_data  = d;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        model(wide, ofs, d);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic settle();
        do @(negedge clk); while (q.size() != 0 || busy);
        repeat (2) @(negedge clk);
    endtask

    // responder: acknowledges after lat waiting cycles
    always @(negedge clk) begin
        if (rst_n) begin
            if (m_ack) begin
                m_ack = 1'b0;
                wcnt  = 0;
            end else if (m_req) begin
                if (wcnt >= lat) begin
                    m_ack   = 1'b1;
                    m_rdata = rd(m_addr);
                end else begin
                    wcnt++;
                end
            end
        end
    end

    // transaction monitor
    always @(posedge clk) begin
        xact_t x;
        if (rst_n && m_req && m_ack) begin
            if (q.size() == 0) begin
                chk("R1 unexpected request", 64'(m_addr), 64'hFFFF_FFFF);
            end else begin
                x = q.pop_front();
                chk("R4 R5 direction", 64'(m_we), 64'(x.we));
                chk("R6 R7 address", 64'(m_addr), 64'(x.addr));
                chk("R8 core", 64'(m_core), 64'(x.core));
                if (x.we) chk("R3 R4 write data", 64'(m_wdata), 64'(x.data));
            end
            if (m_we) mem[int'(m_addr)] = m_wdata;
        end
    end

    // per-cycle comparison of the control outputs
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R10 busy", 64'(busy), 64'(q.size() != 0 || exp_err));
            chk("R10 ready", 64'(cmd_ready), 64'(!(q.size() != 0 || exp_err)));
            chk("R2 err", 64'(cmd_err), 64'(exp_err));
            chk("R1 req", 64'(m_req), 64'(q.size() != 0));
            exp_err = 0;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL R10 watchdog actual=hung expected=idle");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        mem[32'h002C] = 32'h11223344;
        mem[32'h0100] = 32'hDEADBEEF;
        mem[32'h0200] = 32'h01020304;
        mem[32'h0204] = 32'hF0E0D0C0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset ready", 64'(cmd_ready), 64'h1);
        chk("R10 reset busy", 64'(busy), 64'h0);

        // R7 R5: direct command, zero mask
        send(1'b1, ANY, mk(32'hA1B2C3D4, 4'b0000, 10'd1, 16'h1234));
        settle();
        chk("R5 direct full write", 64'(rd(16'h1234)), 64'hA1B2C3D4);

        // R6 R4: mailbox command, keep bytes 0 and 2
        lat = 2;
        send(1'b1, MAIL, mk(32'hAABBCCDD, 4'b0101, 10'd2, 16'h000C));
        settle();
        chk("R4 merged mailbox", 64'(rd(16'h002C)), 64'hAA22CC44);

        // R3: all bytes kept -> unchanged
        send(1'b1, ANY, mk(32'h00000000, 4'b1111, 10'd0, 16'h0100));
        settle();
        chk("R3 all kept", 64'(rd(16'h0100)), 64'hDEADBEEF);

        // R6: stray bits outside word-offset field are dropped; highest valid core
        lat = 0;
        send(1'b1, MAIL, mk(32'h00000055, 4'b0000, 10'd3, 16'hFFE3));
        settle();
        chk("R6 offset masked", 64'(rd(16'h0020)), 64'h00000055);

        // R2: unknown cores
        send(1'b1, ANY, mk(32'h12345678, 4'b0000, 10'd4, 16'h0400));
        settle();
        send(1'b1, ANY, mk(32'h12345678, 4'b0011, 10'd1023, 16'h0400));
        settle();
        chk("R2 no write for bad core", 64'(rd(16'h0400)), 64'h0);

        // R1: narrow access and wrong offset ignored
        send(1'b0, ANY, mk(32'h99999999, 4'b0000, 10'd1, 16'h0300));
        settle();
        send(1'b1, 12'h050, mk(32'h99999999, 4'b0000, 10'd1, 16'h0300));
        settle();
        chk("R1 ignored writes", 64'(rd(16'h0300)), 64'h0);

        // R10 R9: back-to-back commands under slow responder
        lat = 3;
        send(1'b1, ANY, mk(32'hCAFEF00D, 4'b1000, 10'd2, 16'h0200));
        send(1'b1, ANY, mk(32'h11111111, 4'b0110, 10'd3, 16'h0204));
        settle();
        chk("R3 top byte kept", 64'(rd(16'h0200)), 64'h01FEF00D);
        chk("R3 middle kept", 64'(rd(16'h0204)), 64'h11E0D011);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule